// File: doc/BRIEF.md
# Signed Right Shift Unit

This unit performs an arithmetic right shift of a register operand by one to four bit positions and produces the four status flags that go with the result (negative, zero, carry, overflow). It serves a 20-bit datapath and handles two operand widths: the full 20-bit address width, and a 16-bit word width in which bit 15 is the sign and the upper four result bits are cleared.

The sign bit of the active width keeps its value and is copied downward on every step, so the result is the signed operand divided by 2, 4, 8 or 16 and rounded toward negative infinity. Carry receives the last bit shifted out. The whole shift is done in one clock. The caller presents the operand, count and width select with a one-cycle `start_i` strobe. Result and flags are registered on that edge, and `done_o` pulses for one cycle. No back-pressure exists: every strobe is accepted, including one that arrives while `done_o` is high. Result and flags hold their values until the next strobe.

Top module: `sar_unit`

## Requirements
- R1: In long mode (`word_i`=0) the result is the 20-bit two's-complement operand divided by 2^n and rounded toward negative infinity. Bit 19 is the sign and is copied into the vacated upper bits.
- R2: A `count_i` value of k selects a shift of n = k+1 positions (0→1, 1→2, 2→3, 3→4).
- R3: In word mode (`word_i`=1), result bits 15:0 are the signed 16-bit operand bits 15:0 divided by 2^n and rounded toward negative infinity. Result bits 19:16 are zero, and operand bits 19:16 have no effect on any output.
- R4: The carry flag equals operand bit n-1, the last bit shifted out.
- R5: The negative flag equals result bit 19 in long mode and result bit 15 in word mode.
- R6: The zero flag is 1 exactly when the 20-bit result is zero.
- R7: The overflow flag is always 0 after an operation.
- R8: Result, flags and `done_o` are updated on the first rising edge on which `start_i` is high. `done_o` is high for exactly the cycle after each accepted strobe. Back-to-back strobes are each accepted.
- R9: While `start_i` is low, the result and the flags keep their values.
- R10: While reset is active (`rst_n`=0), the result and all flags are 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; inputs are sampled on its edge |
| operand_i | input | 20 | Value to be shifted |
| count_i | input | 2 | Shift count minus one |
| word_i | input | 1 | 1 = 16-bit word mode, 0 = 20-bit long mode |
| result_o | output | 20 | Registered shift result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All results have a latency of one edge. Inputs presented with `start_i` on a rising edge show up on `result_o`, the flags and `done_o` immediately after that same edge. The bench drives inputs on the falling edge and compares every output on the following falling edge, half a cycle after the capture edge. Idle cycles are checked the same way, with `done_o` expected low and the result and flags expected unchanged. Runs of consecutive strobes confirm that each strobe is accepted while `done_o` is still high.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } sar_flags_t;
endpackage

// File: rtl/sar_extend.sv
module sar_extend #(
  parameter int DATA_W = 20,
  parameter int WORD_W = 16
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int UP_W = DATA_W - WORD_W;

  // word mode: replace the upper bits by copies of the word sign
  always_comb begin
    if (word_i) ext_o = {{UP_W{operand_i[WORD_W-1]}}, operand_i[WORD_W-1:0]};
    else        ext_o = operand_i;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DATA_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic [DATA_W-1:0] ext_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] shifted_o,
  output logic              carry_o
);
  localparam int NSTEP = 1 << CNT_W;

  logic [DATA_W-1:0] cand  [NSTEP];
  logic              cycand[NSTEP];

  // one candidate per shift amount, selected by the count
  for (genvar k = 0; k < NSTEP; k++) begin : g_amt
    assign cand[k]   = DATA_W'($signed(ext_i) >>> (k + 1));
    assign cycand[k] = ext_i[k];
  end

  assign shifted_o = cand[count_i];
  assign carry_o   = cycand[count_i];
endmodule

// File: rtl/sar_flags.sv
module sar_flags
  import sar_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int WORD_W = 16
) (
  input  logic [DATA_W-1:0] shifted_i,
  input  logic              carry_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] result_o,
  output sar_flags_t        flags_o
);
  localparam int UP_W = DATA_W - WORD_W;

  always_comb begin
    if (word_i) begin
      result_o      = {{UP_W{1'b0}}, shifted_i[WORD_W-1:0]};
      flags_o.neg   = shifted_i[WORD_W-1];
      flags_o.zero  = (shifted_i[WORD_W-1:0] == '0);
    end else begin
      result_o      = shifted_i;
      flags_o.neg   = shifted_i[DATA_W-1];
      flags_o.zero  = (shifted_i == '0);
    end
    flags_o.carry = carry_i;
    flags_o.ovf   = 1'b0;
  end
endmodule

// File: rtl/sar_unit.sv
module sar_unit
  import sar_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              done_o
);
  logic [DATA_W-1:0] ext, shifted, res_d, res_q;
  logic              carry;
  sar_flags_t        flg_d, flg_q;
  logic              done_q;

  sar_extend #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_ext (
    .operand_i(operand_i), .word_i(word_i), .ext_o(ext)
  );

  sar_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .ext_i(ext), .count_i(count_i), .shifted_o(shifted), .carry_o(carry)
  );

  sar_flags #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_flags (
    .shifted_i(shifted), .carry_i(carry), .word_i(word_i),
    .result_o(res_d), .flags_o(flg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign result_o = res_q;
  assign flag_n_o = flg_q.neg;
  assign flag_z_o = flg_q.zero;
  assign flag_c_o = flg_q.carry;
  assign flag_v_o = flg_q.ovf;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_unit_chk.sv
module sar_unit_chk #(
  parameter int DATA_W = 20,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              word_i,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_c_o,
  input logic              flag_v_o,
  input logic              done_o
);
  // R8
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o)
                 && $stable(flag_c_o) && $stable(flag_v_o));

  // R3
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && word_i) |=> result_o[DATA_W-1:WORD_W] == '0);

  // R4
  carry_last_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> flag_c_o == $past(operand_i[count_i]));

  // R5
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> flag_n_o == ($past(word_i) ? result_o[WORD_W-1] : result_o[DATA_W-1]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> flag_z_o == (result_o == '0));

  // R7
  no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !flag_v_o);
endmodule

bind sar_unit sar_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
  .count_i(count_i), .word_i(word_i), .result_o(result_o),
  .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
  .flag_v_o(flag_v_o), .done_o(done_o)
);

// File: tb/sar_unit_tb_top.sv
module sar_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] operand_i = '0;
  logic [1:0]  count_i = '0;
  logic        word_i = 1'b0;
  logic [19:0] result_o;
  logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .count_i(count_i), .word_i(word_i), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o), .done_o(done_o)
  );

  function automatic logic [19:0] exp_result(logic [19:0] op, logic [1:0] k, logic w);
    logic signed [19:0] s;
    logic [19:0] r;
    int n = int'(k) + 1;
    s = w ? {{4{op[15]}}, op[15:0]} : op;
    r = s >>> n;
    if (w) r[19:16] = 4'h0;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // drive one strobe on a falling edge, then check all outputs at the next falling edge
  task automatic run_op(logic [19:0] op, logic [1:0] k, logic w);
    logic [19:0] er;
    logic en;
    @(negedge clk);
    start_i = 1'b1; operand_i = op; count_i = k; word_i = w;
    er = exp_result(op, k, w);
    en = w ? er[15] : er[19];
    @(negedge clk);
    check(result_o == er, w ? "R3" : "R1", 32'(result_o), 32'(er));
    check(flag_c_o == op[k], "R4", 32'(flag_c_o), 32'(op[k]));
    check(flag_n_o == en, "R5", 32'(flag_n_o), 32'(en));
    check(flag_z_o == (er == 20'h0), "R6", 32'(flag_z_o), 32'(er == 20'h0));
    check(flag_v_o == 1'b0, "R7", 32'(flag_v_o), 32'h0);
    check(done_o == 1'b1, "R8", 32'(done_o), 32'h1);
  endtask

  // one idle cycle with scrambled inputs: nothing may change
  task automatic idle_cycle();
    logic [19:0] r0;
    logic [3:0] f0;
    r0 = result_o;
    f0 = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    start_i = 1'b0; operand_i = 20'($urandom); count_i = 2'($urandom); word_i = 1'($urandom);
    @(negedge clk);
    check(done_o == 1'b0, "R8", 32'(done_o), 32'h0);
    check(result_o == r0, "R9", 32'(result_o), 32'(r0));
    check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == f0, "R9",
          32'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), 32'(f0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    // R10 reset state, with a strobe held during reset
    start_i = 1'b1; operand_i = 20'hFFFFF;
    repeat (3) @(negedge clk);
    check(result_o == 20'h0, "R10", 32'(result_o), 32'h0);
    check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'h0, "R10",
          32'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), 32'h0);
    check(done_o == 1'b0, "R10", 32'(done_o), 32'h0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R8", 32'(done_o), 32'h0);

    // directed corners, R2: each count value in turn on a known pattern
    for (int k = 0; k < 4; k++) run_op(20'h8000F, 2'(k), 1'b0);
    idle_cycle();
    run_op(20'hFFFFF, 2'd3, 1'b0);   // -1 stays -1
    run_op(20'h00001, 2'd0, 1'b0);   // becomes zero, carry 1
    run_op(20'h7FFFF, 2'd3, 1'b0);
    run_op(20'h80000, 2'd0, 1'b0);
    run_op(20'hF8000, 2'd1, 1'b1);   // R3 upper bits ignored, word negative
    run_op(20'h07FFF, 2'd3, 1'b1);   // upper bits ignored, word positive
    run_op(20'hA0008, 2'd3, 1'b1);   // carry from bit 3
    run_op(20'hF0000, 2'd0, 1'b1);   // word value zero, upper ones dropped
    idle_cycle();

    // constrained random mix: back-to-back runs and idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [19:0] op;
      case ($urandom_range(0, 3))
        0: op = 20'($urandom);
        1: op = {4'($urandom), 16'($urandom_range(0, 15))};
        2: op = 20'hFFFF0 | 20'($urandom_range(0, 15));
        default: op = {1'($urandom), 19'($urandom_range(0, 31))};
      endcase
      run_op(op, 2'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle_cycle();
    end
    start_i = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule